// File: doc/BRIEF.md
# Packet Command Launch Sequencer

This block issues the register write sequence that starts a packet command on a parallel ATA device. When `start` is pulsed, it captures a command descriptor and works through a fixed sequence on a simple register access port. The descriptor holds the drive/head byte, the 16-bit byte-count limit, the sector and count bytes, the opcode, a DMA flag, a pre-wait flag and a poll flag. The sequence optionally waits for the device to drop BSY before anything else. It then writes the drive/head register, waits a settle time and waits for BSY to clear. Next it writes the device control register with interrupts enabled, then the parameter registers, and writes the command register last. A second settle time follows the command write.

After the command settle, the block either reports a plain launch, because the device will interrupt when it wants the command packet, or it polls the status register. Polling ends when DRQ, ERR or DF is seen with BSY clear, or when the poll time runs out. A one-cycle `done` pulse carries a 2-bit result code: 0 launched, 1 polled, 2 busy failure. `err_flag` marks a busy failure that came from the optional pre-wait. All delays and timeouts are clock-cycle counts derived from `CLK_HZ`.

State machine: `ST_IDLE` goes on `start` to `ST_PRE_BSY` (pre-wait set) or to `ST_SEL_WR`. `ST_PRE_BSY` goes to `ST_SEL_WR` when BSY is clear, or to `ST_DONE` on timeout. `ST_SEL_WR` goes to `ST_SEL_SETTLE`, then to `ST_SEL_BSY`. `ST_SEL_BSY` goes to `ST_WR_CTL` when BSY is clear, or to `ST_DONE` on timeout. The write states then run in order: `ST_WR_CTL`, `ST_WR_BCLO`, `ST_WR_BCHI`, `ST_WR_SECT`, `ST_WR_CNT`, `ST_WR_FEAT`, `ST_WR_CMD`, `ST_CMD_SETTLE`. From `ST_CMD_SETTLE` the machine goes to `ST_POLL` (poll set) or to `ST_DONE`. `ST_POLL` goes to `ST_DONE` on a hit or on timeout. `ST_DONE` returns to `ST_IDLE`.

Top module: `pkt_cmd_launcher`

## Requirements
- R1: With the pre-wait flag set, the first access is a read of the status register (address 8), repeated every cycle while BSY (bit 7) is set. If BSY is still set at the last of BSY_TMO cycles (CLK_HZ/1e6 × BSY_TMO_US), the block performs no write and pulses `done` with result 2 and `err_flag` 1.
- R2: With the pre-wait flag clear, the access in the first cycle after `start` is a write of the captured drive/head byte to address 1. With the flag set, the same write follows the first status read that shows BSY clear.
- R3: After the drive/head write, status reads continue while BSY is set. If the BSY timeout expires, `done` pulses with result 2 and `err_flag` 0, and no further write occurs.
- R4: Before every command, the device control register (address 0) is written with 0x08, which keeps the interrupt-disable bit (bit 1) clear. This write comes in the cycle after the status read that shows BSY clear.
- R5: In consecutive cycles after the control write, the block writes: byte count low to address 2, byte count high to address 3, sector to address 4, count to address 5, feature to address 6, and the opcode to address 7 as the final write.
- R6: The feature write carries 0x01 when the DMA flag is set and 0x00 when it is clear.
- R7: With the poll flag clear, `done` pulses with result 0 in the cycle after the command settle time.
- R8: With the poll flag set, status reads follow the command settle time. They end with `done` and result 1 when BSY is clear and any of DRQ (bit 3), ERR (bit 0) or DF (bit 5) is set. When DRQ_TMO cycles (CLK_HZ/1e6 × DRQ_TMO_US) pass with no such read, `done` also pulses with result 1.
- R9: After reset there is no access and no `done`. `done` lasts exactly one cycle. `start` is ignored while a sequence runs. The descriptor is captured at `start`, so later input changes have no effect.
- R10: Each settle time (after the drive/head write and after the command write) is ceil(CLK_HZ × 400 ns) cycles, at least 1. During a settle time the port is silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted in idle only) |
| pre_wait_en | input | 1 | Wait for BSY clear before drive select |
| poll_drq | input | 1 | Poll for DRQ/ERR/DF instead of relying on an interrupt |
| dma_en | input | 1 | Command uses DMA (selects feature value) |
| drvhd | input | 8 | Drive/head byte |
| bcount | input | 16 | Byte-count limit |
| sector | input | 8 | Sector register value |
| count | input | 8 | Count register value |
| opcode | input | 8 | Command opcode |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 4 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data (status), valid in the cycle of `reg_rd` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 launched, 1 polled, 2 busy failure |
| err_flag | output | 1 | Busy failure came from the pre-wait (valid with `done`) |

## Verification
A wrong state would show first as a misplaced or missing access on the register port: a write at the wrong address, a read where silence was due, or a settle window one cycle short. This appears within the cycle the state is entered, because every port output is decoded directly from the state. A wrong timeout count or wrong exit condition in one of the three wait states appears as a `done` pulse that comes a cycle early or late, or that carries the wrong result. The bench therefore compares every cycle of port activity against a model, from `start` to `done`.

// File: rtl/pktcmd_pkg.sv
`timescale 1ns/1ps
package pktcmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_BSY,
        ST_SEL_WR,
        ST_SEL_SETTLE,
        ST_SEL_BSY,
        ST_WR_CTL,
        ST_WR_BCLO,
        ST_WR_BCHI,
        ST_WR_SECT,
        ST_WR_CNT,
        ST_WR_FEAT,
        ST_WR_CMD,
        ST_CMD_SETTLE,
        ST_POLL,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_LAUNCHED = 2'd0,
        RES_POLLED   = 2'd1,
        RES_BUSY     = 2'd2,
        RES_RSVD     = 2'd3
    } seq_result_t;

    // register addresses decoded by the device side
    localparam logic [3:0] TF_DEVCTL = 4'd0;
    localparam logic [3:0] TF_DRVHD  = 4'd1;
    localparam logic [3:0] TF_BCLO   = 4'd2;
    localparam logic [3:0] TF_BCHI   = 4'd3;
    localparam logic [3:0] TF_SECT   = 4'd4;
    localparam logic [3:0] TF_CNT    = 4'd5;
    localparam logic [3:0] TF_FEAT   = 4'd6;
    localparam logic [3:0] TF_CMD    = 4'd7;
    localparam logic [3:0] TF_STATUS = 4'd8;

    // status bit positions
    localparam int SB_BSY = 7;
    localparam int SB_DF  = 5;
    localparam int SB_DRQ = 3;
    localparam int SB_ERR = 0;

    localparam logic [7:0] DEVCTL_IRQ_ON = 8'h08;
    localparam logic [7:0] FEAT_DMA      = 8'h01;
    localparam logic [7:0] FEAT_PIO      = 8'h00;

    typedef struct packed {
        logic [7:0]  drvhd;
        logic [15:0] bcount;
        logic [7:0]  sector;
        logic [7:0]  count;
        logic [7:0]  opcode;
        logic        dma;
        logic        poll;
        logic        prewait;
    } cmd_desc_t;

endpackage

// File: rtl/pktcmd_timer.sv
`timescale 1ns/1ps
module pktcmd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10: every state entry starts its window from zero
    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

endmodule

// File: rtl/pktcmd_status_eval.sv
`timescale 1ns/1ps
module pktcmd_status_eval
    import pktcmd_pkg::*;
(
    input  logic [7:0] status,
    output logic       bsy,
    output logic       poll_hit
);
    logic any_flag;

    always_comb begin
        bsy      = status[SB_BSY];
        any_flag = status[SB_DRQ] | status[SB_ERR] | status[SB_DF];
        poll_hit = !bsy && any_flag;
    end

endmodule

// File: rtl/pkt_cmd_launcher.sv
`timescale 1ns/1ps
module pkt_cmd_launcher
    import pktcmd_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned BSY_TMO_US = 5_000_000,
    parameter int unsigned DRQ_TMO_US = 4_000_000,
    parameter int unsigned SETTLE_NS  = 400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        pre_wait_en,
    input  logic        poll_drq,
    input  logic        dma_en,
    input  logic [7:0]  drvhd,
    input  logic [15:0] bcount,
    input  logic [7:0]  sector,
    input  logic [7:0]  count,
    input  logic [7:0]  opcode,
    output logic        reg_wr,
    output logic        reg_rd,
    output logic [3:0]  reg_addr,
    output logic [7:0]  reg_wdata,
    input  logic [7:0]  reg_rdata,
    output logic        done,
    output logic [1:0]  result,
    output logic        err_flag
);
    localparam longint unsigned HZ         = 64'(CLK_HZ);
    localparam longint unsigned SETTLE_RAW = (HZ * 64'(SETTLE_NS) + 64'd999_999_999) / 64'd1_000_000_000;
    localparam longint unsigned SETTLE_CYC = (SETTLE_RAW == 64'd0) ? 64'd1 : SETTLE_RAW;
    localparam longint unsigned BSY_RAW    = HZ * 64'(BSY_TMO_US) / 64'd1_000_000;
    localparam longint unsigned BSY_CYC    = (BSY_RAW == 64'd0) ? 64'd1 : BSY_RAW;
    localparam longint unsigned DRQ_RAW    = HZ * 64'(DRQ_TMO_US) / 64'd1_000_000;
    localparam longint unsigned DRQ_CYC    = (DRQ_RAW == 64'd0) ? 64'd1 : DRQ_RAW;
    localparam longint unsigned MAX_A      = (BSY_CYC > DRQ_CYC) ? BSY_CYC : DRQ_CYC;
    localparam longint unsigned MAX_CYC    = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
    localparam int              CW         = $clog2(MAX_CYC + 64'd1) + 1;

    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 64'd1);
    localparam logic [CW-1:0] BSY_LAST    = CW'(BSY_CYC - 64'd1);
    localparam logic [CW-1:0] DRQ_LAST    = CW'(DRQ_CYC - 64'd1);

    seq_state_t  state_q, state_nxt;
    seq_result_t res_q, res_nxt;
    logic        err_q, err_nxt;
    cmd_desc_t   desc_q;
    logic        st_bsy, st_hit;
    logic        tmr_restart;
    logic [CW-1:0] tmr_cnt;

    pktcmd_status_eval u_stat (
        .status   (reg_rdata),
        .bsy      (st_bsy),
        .poll_hit (st_hit)
    );

    assign tmr_restart = (state_nxt != state_q);

    pktcmd_timer #(.W(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .cnt     (tmr_cnt)
    );

    // next-state and result selection
    always_comb begin
        state_nxt = state_q;
        res_nxt   = RES_LAUNCHED;
        err_nxt   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_nxt = pre_wait_en ? ST_PRE_BSY : ST_SEL_WR;
            end
            ST_PRE_BSY: begin
                if (!st_bsy) begin
                    state_nxt = ST_SEL_WR;
                end else if (tmr_cnt == BSY_LAST) begin
                    state_nxt = ST_DONE;
                    res_nxt   = RES_BUSY;
                    err_nxt   = 1'b1;
                end
            end
            ST_SEL_WR:     state_nxt = ST_SEL_SETTLE;
            ST_SEL_SETTLE: begin
                if (tmr_cnt == SETTLE_LAST) state_nxt = ST_SEL_BSY;
            end
            ST_SEL_BSY: begin
                if (!st_bsy) begin
                    state_nxt = ST_WR_CTL;
                end else if (tmr_cnt == BSY_LAST) begin
                    state_nxt = ST_DONE;
                    res_nxt   = RES_BUSY;
                end
            end
            ST_WR_CTL:  state_nxt = ST_WR_BCLO;
            ST_WR_BCLO: state_nxt = ST_WR_BCHI;
            ST_WR_BCHI: state_nxt = ST_WR_SECT;
            ST_WR_SECT: state_nxt = ST_WR_CNT;
            ST_WR_CNT:  state_nxt = ST_WR_FEAT;
            ST_WR_FEAT: state_nxt = ST_WR_CMD;
            ST_WR_CMD:  state_nxt = ST_CMD_SETTLE;
            ST_CMD_SETTLE: begin
                if (tmr_cnt == SETTLE_LAST) begin
                    state_nxt = desc_q.poll ? ST_POLL : ST_DONE;
                    res_nxt   = RES_LAUNCHED;
                end
            end
            ST_POLL: begin
                if (st_hit || tmr_cnt == DRQ_LAST) begin
                    state_nxt = ST_DONE;
                    res_nxt   = RES_POLLED;
                end
            end
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register, descriptor capture, result latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= RES_LAUNCHED;
            err_q   <= 1'b0;
            desc_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q == ST_IDLE && start) begin
                desc_q <= '{drvhd: drvhd, bcount: bcount, sector: sector,
                            count: count, opcode: opcode, dma: dma_en,
                            poll: poll_drq, prewait: pre_wait_en};
            end
            if (state_nxt == ST_DONE && state_q != ST_DONE) begin
                res_q <= res_nxt;
                err_q <= err_nxt;
            end
        end
    end

    // port outputs decoded from the state
    always_comb begin
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_addr  = TF_DEVCTL;
        reg_wdata = 8'h00;
        unique case (state_q)
            ST_PRE_BSY, ST_SEL_BSY, ST_POLL: begin
                reg_rd   = 1'b1;
                reg_addr = TF_STATUS;
            end
            ST_SEL_WR: begin
                reg_wr = 1'b1; reg_addr = TF_DRVHD; reg_wdata = desc_q.drvhd;
            end
            ST_WR_CTL: begin
                reg_wr = 1'b1; reg_addr = TF_DEVCTL; reg_wdata = DEVCTL_IRQ_ON;
            end
            ST_WR_BCLO: begin
                reg_wr = 1'b1; reg_addr = TF_BCLO; reg_wdata = desc_q.bcount[7:0];
            end
            ST_WR_BCHI: begin
                reg_wr = 1'b1; reg_addr = TF_BCHI; reg_wdata = desc_q.bcount[15:8];
            end
            ST_WR_SECT: begin
                reg_wr = 1'b1; reg_addr = TF_SECT; reg_wdata = desc_q.sector;
            end
            ST_WR_CNT: begin
                reg_wr = 1'b1; reg_addr = TF_CNT; reg_wdata = desc_q.count;
            end
            ST_WR_FEAT: begin
                reg_wr = 1'b1; reg_addr = TF_FEAT;
                reg_wdata = desc_q.dma ? FEAT_DMA : FEAT_PIO;
            end
            ST_WR_CMD: begin
                reg_wr = 1'b1; reg_addr = TF_CMD; reg_wdata = desc_q.opcode;
            end
            default: ;
        endcase
    end

    assign done     = (state_q == ST_DONE);
    assign result   = res_q;
    assign err_flag = done && err_q;

    // R5: reads and writes never share a cycle
    assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R5: the byte-count low write directly follows the control write
    assert_ctl_then_params_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == TF_BCLO) |-> $past(reg_wr && reg_addr == TF_DEVCTL));

    // R10: silence after the drive/head write
    assert_sel_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == TF_DRVHD) |=> (!reg_wr && !reg_rd));

    // R7: no access and no completion right after the command write
    assert_cmd_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == TF_CMD) |=> (!reg_wr && !reg_rd && !done));

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: the error flag only accompanies a busy result
    assert_err_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (done && result == RES_BUSY));

    // R8: the reserved result code never completes
    assert_no_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != RES_RSVD));

endmodule

// File: tb/sim_pkt_cmd_launcher.sv
`timescale 1ns/1ps
module sim_pkt_cmd_launcher;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned T_CLK_HZ = 10_000_000;
    localparam int unsigned T_BSY_US = 50;
    localparam int unsigned T_DRQ_US = 40;
    localparam int B_SETTLE = int'((longint'(T_CLK_HZ) * 400 + 999_999_999) / 1_000_000_000);
    localparam int B_BSY    = int'(T_CLK_HZ / 1_000_000) * int'(T_BSY_US);
    localparam int B_DRQ    = int'(T_CLK_HZ / 1_000_000) * int'(T_DRQ_US);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, pre_wait_en = 1'b0, poll_drq = 1'b0, dma_en = 1'b0;
    logic [7:0] drvhd = 8'h0, sector = 8'h0, count = 8'h0, opcode = 8'h0;
    logic [15:0] bcount = 16'h0;
    logic reg_wr, reg_rd, done, err_flag;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [1:0] result;

    int n_checks = 0, n_errors = 0;
    bit finished = 0;

    // device model state
    int bsy_left = 0;
    int sel_bsy_v = 0, poll_bsy_v = 0;
    logic [7:0] poll_flags_v = 8'h0;
    bit poll_phase = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_cmd_launcher #(.CLK_HZ(T_CLK_HZ), .BSY_TMO_US(T_BSY_US), .DRQ_TMO_US(T_DRQ_US)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pre_wait_en(pre_wait_en),
        .poll_drq(poll_drq), .dma_en(dma_en), .drvhd(drvhd), .bcount(bcount),
        .sector(sector), .count(count), .opcode(opcode), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .done(done), .result(result), .err_flag(err_flag)
    );

    assign reg_rdata = {(bsy_left > 0), 7'b0} | (poll_phase ? poll_flags_v : 8'h00);

    always @(posedge clk) begin
        if (reg_rd && reg_addr == 4'd8 && bsy_left > 0) bsy_left <= bsy_left - 1;
        if (reg_wr && reg_addr == 4'd1) bsy_left <= sel_bsy_v;
        if (reg_wr && reg_addr == 4'd7) begin
            bsy_left   <= poll_bsy_v;
            poll_phase <= 1'b1;
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] tk(bit d, bit w, bit r, logic [3:0] a,
                                       logic [7:0] v, logic [1:0] res, bit e);
        return {d, w, r, a, v, res, e};
    endfunction

    logic [17:0] exp_q[$];
    string       exp_tag[$];
    logic [17:0] act_q[$];

    task automatic push(logic [17:0] t, string tag);
        exp_q.push_back(t);
        exp_tag.push_back(tag);
    endtask

    task automatic build_expected(bit pre, bit poll, bit dma, logic [7:0] drv,
                                  logic [15:0] bc, logic [7:0] sec, logic [7:0] cnt,
                                  logic [7:0] op, int pre_bsy, int sel_bsy,
                                  int poll_bsy, logic [7:0] pflags);
        exp_q.delete();
        exp_tag.delete();
        if (pre) begin
            if (pre_bsy >= B_BSY) begin
                for (int i = 0; i < B_BSY; i++) push(tk(0,0,1,4'd8,8'h0,2'd0,0), "R1");
                push(tk(1,0,0,4'd0,8'h0,2'd2,1), "R1");
                return;
            end
            for (int i = 0; i <= pre_bsy; i++) push(tk(0,0,1,4'd8,8'h0,2'd0,0), "R1");
        end
        push(tk(0,1,0,4'd1,drv,2'd0,0), "R2");
        for (int i = 0; i < B_SETTLE; i++) push(18'h0, "R10");
        if (sel_bsy >= B_BSY) begin
            for (int i = 0; i < B_BSY; i++) push(tk(0,0,1,4'd8,8'h0,2'd0,0), "R3");
            push(tk(1,0,0,4'd0,8'h0,2'd2,0), "R3");
            return;
        end
        for (int i = 0; i <= sel_bsy; i++) push(tk(0,0,1,4'd8,8'h0,2'd0,0), "R3");
        push(tk(0,1,0,4'd0,8'h08,2'd0,0), "R4");
        push(tk(0,1,0,4'd2,bc[7:0],2'd0,0), "R5");
        push(tk(0,1,0,4'd3,bc[15:8],2'd0,0), "R5");
        push(tk(0,1,0,4'd4,sec,2'd0,0), "R5");
        push(tk(0,1,0,4'd5,cnt,2'd0,0), "R5");
        push(tk(0,1,0,4'd6,dma ? 8'h01 : 8'h00,2'd0,0), "R6");
        push(tk(0,1,0,4'd7,op,2'd0,0), "R5");
        for (int i = 0; i < B_SETTLE; i++) push(18'h0, "R10");
        if (!poll) begin
            push(tk(1,0,0,4'd0,8'h0,2'd0,0), "R7");
        end else begin
            bit hit;
            int n;
            hit = (pflags != 8'h0) && (poll_bsy < B_DRQ);
            n = hit ? poll_bsy + 1 : B_DRQ;
            for (int i = 0; i < n; i++) push(tk(0,0,1,4'd8,8'h0,2'd0,0), "R8");
            push(tk(1,0,0,4'd0,8'h0,2'd1,0), "R8");
        end
    endtask

    task automatic run_seq(bit pre, bit poll, bit dma, int pre_bsy, int sel_bsy,
                           int poll_bsy, logic [7:0] pflags, bit glitch);
        logic [7:0] drv, sec, cnt, op;
        logic [15:0] bc;
        logic [17:0] t;
        int mism;
        drv = 8'($urandom); sec = 8'($urandom); cnt = 8'($urandom);
        op = 8'($urandom); bc = 16'($urandom);
        build_expected(pre, poll, dma, drv, bc, sec, cnt, op, pre_bsy, sel_bsy, poll_bsy, pflags);
        act_q.delete();
        @(negedge clk);
        bsy_left = pre_bsy; sel_bsy_v = sel_bsy; poll_bsy_v = poll_bsy;
        poll_flags_v = pflags; poll_phase = 0;
        start = 1'b1; pre_wait_en = pre; poll_drq = poll; dma_en = dma;
        drvhd = drv; bcount = bc; sector = sec; count = cnt; opcode = op;
        @(negedge clk);
        // R9: later descriptor changes and a second start are ignored
        start = glitch;
        pre_wait_en = ~pre; poll_drq = ~poll; dma_en = ~dma;
        drvhd = ~drv; bcount = ~bc; sector = ~sec; count = ~cnt; opcode = ~op;
        for (int k = 0; k < exp_q.size() + 4; k++) begin
            if (k == 1) start = 1'b0;
            t = tk(done, reg_wr, reg_rd, (reg_wr | reg_rd) ? reg_addr : 4'h0,
                   reg_wr ? reg_wdata : 8'h0, done ? result : 2'b0, done ? err_flag : 1'b0);
            act_q.push_back(t);
            if (done) break;
            @(negedge clk);
        end
        start = 1'b0;
        check(act_q.size() == exp_q.size(), exp_tag[exp_q.size()-1], "sequence length",
              act_q.size(), exp_q.size());
        mism = -1;
        for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
            if (mism < 0 && act_q[i] !== exp_q[i]) mism = i;
        if (mism >= 0)
            check(0, exp_tag[mism], $sformatf("cycle %0d token", mism + 1), act_q[mism], exp_q[mism]);
        else
            check(1, exp_tag[exp_q.size()-1], "tokens", 0, 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done after pulse", done, 0);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check(reg_wr == 1'b0 && reg_rd == 1'b0, "R9", "access in reset", {reg_wr, reg_rd}, 0);
        check(done == 1'b0, "R9", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_wr == 1'b0 && reg_rd == 1'b0 && done == 1'b0, "R9", "idle after reset",
              {reg_wr, reg_rd, done}, 0);

        // R2: no pre-wait, interrupt launch (R7), PIO feature (R6)
        run_seq(0, 0, 0, 0, 0, 0, 8'h00, 0);
        // R6: DMA feature
        run_seq(0, 0, 1, 0, 3, 0, 8'h00, 0);
        // R1: pre-wait passes at the last allowed read
        run_seq(1, 0, 0, B_BSY - 1, 0, 0, 8'h00, 0);
        // R1: pre-wait timeout with error flag
        run_seq(1, 0, 0, B_BSY, 0, 0, 8'h00, 0);
        // R3: select wait timeout without error flag
        run_seq(0, 0, 0, 0, B_BSY + 20, 0, 8'h00, 0);
        // R8: DRQ held off by BSY, then hit
        run_seq(0, 1, 0, 0, 2, 12, 8'h08, 0);
        // R8: ERR and DF each end the poll
        run_seq(0, 1, 1, 0, 0, 0, 8'h01, 0);
        run_seq(1, 1, 0, 5, 1, 3, 8'h20, 0);
        // R8: poll timeout still reports polled
        run_seq(0, 1, 0, 0, 0, 0, 8'h00, 0);
        // R9: start during a running sequence is ignored
        run_seq(1, 1, 1, 4, 4, 4, 8'h09, 1);
        run_seq(0, 0, 0, 0, 0, 0, 8'h00, 1);

        // random mix (R5, R10 on every pass)
        for (int n = 0; n < 40; n++) begin
            logic [7:0] fl;
            case ($urandom % 5)
                0: fl = 8'h08;
                1: fl = 8'h01;
                2: fl = 8'h20;
                3: fl = 8'h29;
                default: fl = ($urandom % 4 == 0) ? 8'h00 : 8'h08;
            endcase
            run_seq(1'($urandom), 1'($urandom), 1'($urandom),
                    int'($urandom % 20), int'($urandom % 20), int'($urandom % 20),
                    fl, 1'($urandom));
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule